// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable integer ratio using the pulse-swallow method. A dual-modulus prescaler counts groups of P or P+1 input cycles, where P is 16 at the default size. A swallow counter decides how many groups use the longer length. A main counter decides how many groups make up one output period. With the divide word split into a main count M (upper bits) and a swallow count A (lower bits), one output period lasts P·M + A input cycles. The block is meant to feed a phase comparator with the divided oscillator signal.

The divide word is sampled only when a period ends, so every period has one length. Ratios below the smallest legal value P·(P−1) (240 at the default size) are replaced by that minimum, and a flag shows that the requested word was too small. Each period ends with a one-cycle pulse, and a second output toggles on each pulse, which gives the divided signal halved for a test pin.

The controller has three states. IDLE is entered on reset and lasts one cycle; it loads the word and goes to SWALLOW if A is nonzero, otherwise to NORMAL. SWALLOW selects the P+1 modulus and goes to NORMAL when the last swallow group ends. NORMAL selects the P modulus. From SWALLOW or NORMAL, the end of the last group reloads the word and moves to SWALLOW or NORMAL according to the new A.

Top module: `pulse_swallow_div`

## Requirements
- R1: The divide word is split into M = div_word[W-1:A_BITS] and A = div_word[A_BITS-1:0], with P = 2**A_BITS. For a legal word, successive div_pulse assertions are exactly P·M + A clk cycles apart.
- R2: In each period the first A prescaler groups last P+1 cycles and the remaining M−A groups last P cycles. The swallow count never exceeds the remaining main count.
- R3: div_pulse is high for exactly one clk cycle per period.
- R4: A word below N_MIN = P·(P−1) (240 by default) gives a period of N_MIN cycles. ratio_low is high, combinationally, exactly when div_word < N_MIN.
- R5: div_word is sampled only at a period boundary. A word changed in mid-period leaves that period at its old length, and the following period uses the new word.
- R6: div_half is 0 after reset and inverts on the same clock edge at which each div_pulse rises. Its period is therefore twice the divide ratio.
- R7: While rst_n is low, div_pulse and div_half are 0. The first div_pulse rises on the (N+1)-th rising edge after the first rising edge with rst_n high, where N is the effective ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| div_word | input | M_BITS+A_BITS | Requested divide ratio (main count in the upper bits, swallow count in the lower bits) |
| div_pulse | output | 1 | One-cycle pulse at the end of each output period |
| div_half | output | 1 | Divided output halved, for test observation |
| ratio_low | output | 1 | High when div_word is below the legal minimum |

## Verification
The hardest situation to reach from the ports is a change of the divide word in the middle of a period, including a change from an illegal word to a legal one or back. The difficulty is telling whether the new value leaked into the period already running. The bench uses a small size (P = 4, 6-bit word) and walks through every word value. Each new word is applied at a different offset inside the running period. The bench checks that the interrupted period keeps the previous effective length and that the next period takes the new one. This also covers the corner where M equals A, so the swallow phase fills the whole period.

// File: rtl/dm_div_pkg.sv
package dm_div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_NORMAL  = 2'd2
    } dm_state_e;
endpackage

// File: rtl/dm_ratio_clamp.sv
module dm_ratio_clamp #(
    parameter int M_BITS = 11,
    parameter int A_BITS = 4
) (
    input  logic [M_BITS+A_BITS-1:0] word_in,
    output logic [M_BITS-1:0]        m_val,
    output logic [A_BITS-1:0]        a_val,
    output logic                     too_low
);
    localparam int W     = M_BITS + A_BITS;
    localparam int P     = 1 << A_BITS;
    localparam int N_MIN = P * (P - 1);
    localparam logic [W-1:0] N_MIN_W = W'(N_MIN);

    logic [W-1:0] eff_word;

    always_comb begin
        too_low  = (word_in < N_MIN_W);
        eff_word = too_low ? N_MIN_W : word_in;
        m_val    = eff_word[W-1:A_BITS];
        a_val    = eff_word[A_BITS-1:0];
    end
endmodule

// File: rtl/dm_prescaler.sv
module dm_prescaler #(
    parameter int A_BITS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic swallow,
    output logic pre_tc
);
    localparam int P  = 1 << A_BITS;
    localparam int CW = $clog2(P + 1);

    logic [CW-1:0] pc;
    logic [CW-1:0] last_val;

    always_comb begin
        last_val = swallow ? CW'(P) : CW'(P - 1);
        pre_tc   = (pc == last_val);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (clr || pre_tc) begin
            pc <= '0;
        end else begin
            pc <= pc + CW'(1);
        end
    end

    // R2: a short (P) group never counts past P-1
    assert_short_group_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !swallow |-> (pc < CW'(P)));
    // R2: a long group never counts past P
    assert_long_group_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pc <= CW'(P));
endmodule

// File: rtl/dm_ctrl.sv
module dm_ctrl
    import dm_div_pkg::*;
#(
    parameter int M_BITS = 11,
    parameter int A_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_tc,
    input  logic [M_BITS-1:0] m_new,
    input  logic [A_BITS-1:0] a_new,
    output logic              swallow,
    output logic              presc_clr,
    output logic              div_pulse,
    output logic              div_half
);
    dm_state_e         state, nxt;
    logic [M_BITS-1:0] m_cnt;
    logic [A_BITS-1:0] a_cnt;
    logic              last_group;
    dm_state_e         load_state;

    always_comb begin
        last_group = pre_tc && (m_cnt == M_BITS'(1));
        load_state = (a_new != '0) ? ST_SWALLOW : ST_NORMAL;
        nxt        = state;
        unique case (state)
            ST_IDLE:    nxt = load_state;
            ST_SWALLOW: begin
                if (last_group)
                    nxt = load_state;
                else if (pre_tc && (a_cnt == A_BITS'(1)))
                    nxt = ST_NORMAL;
            end
            ST_NORMAL:  begin
                if (last_group)
                    nxt = load_state;
            end
            default:    nxt = ST_IDLE;
        endcase
        swallow   = (state == ST_SWALLOW);
        presc_clr = (state == ST_IDLE);
    end

    // state register with its counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            m_cnt <= '0;
            a_cnt <= '0;
        end else begin
            state <= nxt;
            if ((state == ST_IDLE) || last_group) begin
                m_cnt <= m_new;
                a_cnt <= a_new;
            end else if (pre_tc) begin
                m_cnt <= m_cnt - M_BITS'(1);
                if (a_cnt != '0)
                    a_cnt <= a_cnt - A_BITS'(1);
            end
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_pulse <= 1'b0;
            div_half  <= 1'b0;
        end else begin
            div_pulse <= last_group;
            if (last_group)
                div_half <= ~div_half;
        end
    end

    // R2: the long modulus is selected only while swallow groups remain
    assert_swallow_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWALLOW) |-> (a_cnt != '0));
    // R2: swallow count fits inside the remaining main count
    assert_swallow_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> ({{M_BITS{1'b0}}, a_cnt} <= {{A_BITS{1'b0}}, m_cnt}));
    // R4: clamping keeps the main count from ever running empty
    assert_main_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (m_cnt != '0));
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
    parameter int M_BITS = 11,
    parameter int A_BITS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [M_BITS+A_BITS-1:0] div_word,
    output logic                     div_pulse,
    output logic                     div_half,
    output logic                     ratio_low
);
    logic [M_BITS-1:0] m_val;
    logic [A_BITS-1:0] a_val;
    logic              swallow;
    logic              presc_clr;
    logic              pre_tc;

    dm_ratio_clamp #(.M_BITS(M_BITS), .A_BITS(A_BITS)) u_clamp (
        .word_in (div_word),
        .m_val   (m_val),
        .a_val   (a_val),
        .too_low (ratio_low)
    );

    dm_prescaler #(.A_BITS(A_BITS)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (presc_clr),
        .swallow (swallow),
        .pre_tc  (pre_tc)
    );

    dm_ctrl #(.M_BITS(M_BITS), .A_BITS(A_BITS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_tc    (pre_tc),
        .m_new     (m_val),
        .a_new     (a_val),
        .swallow   (swallow),
        .presc_clr (presc_clr),
        .div_pulse (div_pulse),
        .div_half  (div_half)
    );

    // R3: output pulse lasts one cycle
    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);
    // R6: halved output changes together with each pulse
    assert_half_toggles_R6: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> (div_half != $past(div_half)));
    // R6: halved output holds between pulses
    assert_half_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !div_pulse |-> $stable(div_half));
endmodule

// File: tb/sim_pulse_swallow_div.sv
module sim_pulse_swallow_div;
    localparam int MB   = 4;
    localparam int AB   = 2;
    localparam int W    = MB + AB;
    localparam int P    = 1 << AB;
    localparam int NMIN = P * (P - 1);

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] div_word;
    logic         div_pulse, div_half, ratio_low;

    int checks = 0;
    int errors = 0;
    int cur_word;
    logic last_half;

    always #4 clk = ~clk;

    pulse_swallow_div #(.M_BITS(MB), .A_BITS(AB)) u0 (
        .clk(clk), .rst_n(rst_n), .div_word(div_word),
        .div_pulse(div_pulse), .div_half(div_half), .ratio_low(ratio_low)
    );

    function automatic int eff(input int w);
        return (w < NMIN) ? NMIN : w;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts negedges until div_pulse is seen, starting from 'start'
    task automatic count_to_pulse(input int start, input bit chk_single, output int iv);
        iv = start;
        do begin
            @(negedge clk);
            iv++;
            if (chk_single && iv == start + 1)
                check(div_pulse == 1'b0, "R3 pulse width", div_pulse, 0);
        end while (!div_pulse && iv < 1000);
        check(div_half != last_half, "R6 half toggle", div_half, !last_half);
        last_half = div_half;
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int iv;
        rst_n    = 1'b0;
        div_word = W'(20);
        cur_word = 20;
        last_half = 1'b0;
        repeat (3) @(negedge clk);
        check(div_pulse == 1'b0, "R7 reset pulse", div_pulse, 0);
        check(div_half == 1'b0, "R7 R6 reset half", div_half, 0);
        rst_n = 1'b1;
        count_to_pulse(0, 1'b0, iv);
        check(iv == eff(20) + 1, "R7 first pulse", iv, eff(20) + 1);
        count_to_pulse(0, 1'b1, iv);
        check(iv == eff(20), "R1 period", iv, eff(20));

        for (int w = 0; w < (1 << W); w++) begin
            int d;
            int pre;
            d   = w % 5;
            pre = 0;
            repeat (d) begin
                @(negedge clk);
                pre++;
            end
            div_word = W'(w);
            #1;
            check(ratio_low == (w < NMIN), "R4 ratio_low flag", ratio_low, (w < NMIN));
            count_to_pulse(pre, 1'b0, iv);
            check(iv == eff(cur_word), "R5 period in flight keeps old word", iv, eff(cur_word));
            count_to_pulse(0, 1'b1, iv);
            if (w < NMIN)
                check(iv == NMIN, "R4 clamped period", iv, NMIN);
            else
                check(iv == P * (w / P) + (w % P), "R1 R2 period P*M+A", iv, P * (w / P) + (w % P));
            cur_word = w;
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule